// File: doc/BRIEF.md
# Lockable Watchdog Timer

A memory-mapped watchdog built around a down-counter. Software programs a reload value, turns on the interrupt and, if wanted, the reset stage. The counter then counts down by one each clock. When the counter reaches zero while no timeout is pending, the block raises a timeout interrupt and starts again from the reload value. If the counter reaches zero a second time before software has acknowledged the first timeout, and the reset stage is enabled, the block raises a reset request toward the system reset controller. This request stays high until the block's own reset.

Every register except the lock register can be frozen by a key-protected lock. Only the correct key reopens them, and any other value written to the lock register closes them again. One bit stays writable while locked: the test bit that turns the reset request into a logged cause bit plus an interrupt. A debug-halt input can freeze the counter, but only when the stall bit is set. The interrupt enable is sticky, so software can set it but cannot clear it. The interrupt is routed either to a maskable line or to a non-maskable line, depending on a control bit.

The register bus has one write port and one read port, both addressed by word offset. Writes take effect at the clock edge. Reads are combinational from the current state.

Top module: `wdog_lockable`

## Requirements
- R1: After reset the block is unlocked: the lock register (offset 8) reads 0. The reload register (offset 0) and the count readback (offset 1) read all ones. Control (offset 2), test (offset 6), raw status (offset 4) and cause (offset 7) read 0. The irq, nmi and rst_req outputs are low.
- R2: A write to offset 0 stores the reload value and copies it into the counter at the same edge. The counter counts only while interrupt enable (control bit 0) is set. It then drops by one per clock, and offset 1 returns the current count.
- R3: Writing 0 to offset 0 sets the raw timeout status (offset 4, bit 0) at the same edge, whether or not the interrupt is enabled.
- R4: When the counter is at zero while counting and the raw status is clear, the raw status is set and the counter is reloaded from the reload register. With reload N, this happens N+1 clocks after the reload write.
- R5: When the counter is at zero while counting, the raw status is already set, reset enable (control bit 1) is 1 and test bit 0 is 0, the rst_req output goes high. It then stays high until the block is reset, even after an acknowledge.
- R6: In that same second-timeout case with test bit 0 set, rst_req stays low and cause bit 1 is set. The interrupt stays raised. Cause bit 0 always mirrors the raw status.
- R7: A write of any value to offset 3 clears the raw status and cause bit 1, and reloads the counter from the reload register.
- R8: The masked status (offset 5, bit 0) is the raw status ANDed with interrupt enable. The masked status drives the irq output when interrupt type (control bit 2) is 0, and the nmi output when that bit is 1.
- R9: Once control bit 0 is set, writing 0 to it leaves it at 1. Only a block reset clears it. Control bits 1 and 2 are ordinary read/write bits.
- R10: With stall enable (test bit 8) set, a high dbg_halt freezes the counter, and counting resumes when dbg_halt falls. With test bit 8 clear, dbg_halt has no effect.
- R11: Writing 0x1ACCE551 to offset 8 unlocks the block, and writing any other value to offset 8 locks it. Offset 8 reads 1 while locked and 0 while unlocked. While locked, writes to offsets 0, 2 and 3 and to test bit 8 are ignored, but test bit 0 is still written.
- R12: Writes to unmapped offsets (9 to 15) and to the read-only offsets 1, 4, 5 and 7 change nothing. Reads of unmapped offsets and of offset 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per asserted clock |
| wr_addr | input | ADDR_W | Word offset of the write |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Word offset of the read |
| rd_data | output | DATA_W | Combinational read data |
| dbg_halt | input | 1 | Debug halt request from the processor |
| irq | output | 1 | Maskable timeout interrupt |
| nmi | output | 1 | Non-maskable timeout interrupt |
| rst_req | output | 1 | Sticky reset request to the system reset controller |

## Verification
A write presented before a clock edge is visible on the first read sampled after that edge. For a reload write, that first read returns the reload value itself. Each later cycle lowers the count by one. So the first timeout shows N+1 cycles after a reload of N, and the second timeout shows 2(N+1) cycles after it. The bench issues one read per cycle, each half a cycle before the edge it observes, and its queued expected values are computed from these cycle counts. The outputs irq, nmi and rst_req come straight from registers, so they are checked in the same sampled cycle as the register reads.

// File: rtl/wdog_lockable_pkg.sv
package wdog_lockable_pkg;

  // word offsets of the register map
  localparam int unsigned OFS_RELOAD  = 0;
  localparam int unsigned OFS_COUNT   = 1;
  localparam int unsigned OFS_CTRL    = 2;
  localparam int unsigned OFS_ACK     = 3;
  localparam int unsigned OFS_RAW     = 4;
  localparam int unsigned OFS_MASKED  = 5;
  localparam int unsigned OFS_TEST    = 6;
  localparam int unsigned OFS_CAUSE   = 7;
  localparam int unsigned OFS_KEYLOCK = 8;

  // bit positions inside control and test words
  localparam int unsigned CTRL_IRQEN_BIT = 0;
  localparam int unsigned CTRL_RSTEN_BIT = 1;
  localparam int unsigned CTRL_KIND_BIT  = 2;
  localparam int unsigned TEST_NORST_BIT = 0;
  localparam int unsigned TEST_STALL_BIT = 8;

  localparam logic [31:0] UNLOCK_KEY = 32'h1ACC_E551;

  typedef struct packed {
    logic irq_kind;  // 1: route to non-maskable line
    logic rst_en;
    logic irq_en;    // sticky
  } ctrl_t;

  typedef struct packed {
    logic stall_en;
    logic no_reset;
  } test_t;

endpackage

// File: rtl/wdog_regfile.sv
module wdog_regfile
  import wdog_lockable_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter logic [DATA_W-1:0] KEY = DATA_W'(UNLOCK_KEY)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] reload_q,
  output ctrl_t             ctrl_q,
  output test_t             test_q,
  output logic              locked_q,
  output logic              reload_wr,
  output logic              ack_wr
);

  function automatic logic addr_is(input logic [ADDR_W-1:0] a, input int unsigned ofs);
    return a == ADDR_W'(ofs);
  endfunction

  // the enable bit may only rise; the other two follow the data
  function automatic ctrl_t ctrl_merge(input ctrl_t cur, input logic [DATA_W-1:0] d);
    ctrl_t n;
    n.irq_en   = cur.irq_en | d[CTRL_IRQEN_BIT];
    n.rst_en   = d[CTRL_RSTEN_BIT];
    n.irq_kind = d[CTRL_KIND_BIT];
    return n;
  endfunction

  function automatic logic key_match(input logic [DATA_W-1:0] d);
    return d == KEY;
  endfunction

  logic hit_reload, hit_ctrl, hit_ack, hit_test, hit_lock, hit_unmapped;
  logic open_w, ctrl_wr, test_wr, lock_wr;

  assign hit_reload   = wr_en && addr_is(wr_addr, OFS_RELOAD);
  assign hit_ctrl     = wr_en && addr_is(wr_addr, OFS_CTRL);
  assign hit_ack      = wr_en && addr_is(wr_addr, OFS_ACK);
  assign hit_test     = wr_en && addr_is(wr_addr, OFS_TEST);
  assign hit_lock     = wr_en && addr_is(wr_addr, OFS_KEYLOCK);
  assign hit_unmapped = wr_en && (wr_addr > ADDR_W'(OFS_KEYLOCK));

  assign open_w    = !locked_q;
  assign reload_wr = hit_reload && open_w;
  assign ack_wr    = hit_ack && open_w;
  assign ctrl_wr   = hit_ctrl && open_w;
  assign test_wr   = hit_test;
  assign lock_wr   = hit_lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '1;
      ctrl_q   <= '0;
      test_q   <= '0;
      locked_q <= 1'b0;
    end else begin
      if (reload_wr) reload_q <= wr_data;
      if (ctrl_wr)   ctrl_q   <= ctrl_merge(ctrl_q, wr_data);
      if (test_wr) begin
        test_q.no_reset <= wr_data[TEST_NORST_BIT];
        if (open_w) test_q.stall_en <= wr_data[TEST_STALL_BIT];
      end
      if (lock_wr) locked_q <= !key_match(wr_data);
    end
  end

  assert_irqen_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.irq_en |=> ctrl_q.irq_en);

  assert_locked_reload_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && hit_reload) |=> $stable(reload_q));

  assert_locked_ctrl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && hit_ctrl) |=> $stable(ctrl_q));

  assert_locked_test_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && hit_test) |=> ($stable(test_q.stall_en) &&
                                test_q.no_reset == $past(wr_data[TEST_NORST_BIT])));

  assert_unmapped_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    hit_unmapped |=> ($stable(reload_q) && $stable(ctrl_q) && $stable(test_q) &&
                      $stable(locked_q)));

endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_lockable_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reload_wr,
  input  logic [DATA_W-1:0] reload_data,
  input  logic              ack_wr,
  input  logic [DATA_W-1:0] reload_q,
  input  ctrl_t             ctrl_q,
  input  test_t             test_q,
  input  logic              dbg_halt,
  output logic [DATA_W-1:0] count_q,
  output logic              raw_q,
  output logic              cause_rst_q,
  output logic              rst_req_q
);

  function automatic logic [DATA_W-1:0] count_step(input logic [DATA_W-1:0] c);
    return c - DATA_W'(1);
  endfunction

  function automatic logic is_zero(input logic [DATA_W-1:0] c);
    return c == '0;
  endfunction

  // named events for the checks
  logic run, bus_touch, at_zero, first_hit, second_hit, load_zero;

  assign run        = ctrl_q.irq_en && !(test_q.stall_en && dbg_halt);
  assign bus_touch  = reload_wr || ack_wr;
  assign at_zero    = run && is_zero(count_q) && !bus_touch;
  assign first_hit  = at_zero && !raw_q;
  assign second_hit = at_zero && raw_q && ctrl_q.rst_en;
  assign load_zero  = reload_wr && is_zero(reload_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q     <= '1;
      raw_q       <= 1'b0;
      cause_rst_q <= 1'b0;
      rst_req_q   <= 1'b0;
    end else begin
      if (reload_wr)      count_q <= reload_data;
      else if (ack_wr)    count_q <= reload_q;
      else if (at_zero)   count_q <= reload_q;
      else if (run)       count_q <= count_step(count_q);

      if (ack_wr)                       raw_q <= 1'b0;
      else if (load_zero || first_hit)  raw_q <= 1'b1;

      if (ack_wr)                             cause_rst_q <= 1'b0;
      else if (second_hit && test_q.no_reset) cause_rst_q <= 1'b1;

      if (second_hit && !test_q.no_reset) rst_req_q <= 1'b1;
    end
  end

  assert_count_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !is_zero(count_q) && !bus_touch) |=> count_q == $past(count_q) - DATA_W'(1));

  assert_load_copy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reload_wr |=> count_q == $past(reload_data));

  assert_zero_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_zero |=> raw_q);

  assert_first_timeout_R4: assert property (@(posedge clk) disable iff (!rst_n)
    first_hit |=> (raw_q && count_q == $past(reload_q)));

  assert_reset_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (second_hit && !test_q.no_reset) |=> rst_req_q);

  assert_reset_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_q |=> rst_req_q);

  assert_test_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (second_hit && test_q.no_reset && !rst_req_q) |=> (cause_rst_q && !rst_req_q && raw_q));

  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_wr |=> (!raw_q && !cause_rst_q && count_q == $past(reload_q)));

  assert_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !bus_touch) |=> $stable(count_q));

endmodule

// File: rtl/wdog_rdmux.sv
module wdog_rdmux
  import wdog_lockable_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] reload_q,
  input  logic [DATA_W-1:0] count_q,
  input  ctrl_t             ctrl_q,
  input  test_t             test_q,
  input  logic              locked_q,
  input  logic              raw_q,
  input  logic              cause_rst_q,
  output logic [DATA_W-1:0] rd_data
);

  function automatic logic [DATA_W-1:0] ctrl_word(input ctrl_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[CTRL_IRQEN_BIT] = c.irq_en;
    w[CTRL_RSTEN_BIT] = c.rst_en;
    w[CTRL_KIND_BIT]  = c.irq_kind;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] test_word(input test_t t);
    logic [DATA_W-1:0] w;
    w = '0;
    w[TEST_NORST_BIT] = t.no_reset;
    w[TEST_STALL_BIT] = t.stall_en;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] flags(input logic b1, input logic b0);
    logic [DATA_W-1:0] w;
    w = '0;
    w[1] = b1;
    w[0] = b0;
    return w;
  endfunction

  always_comb begin
    case (rd_addr)
      ADDR_W'(OFS_RELOAD):  rd_data = reload_q;
      ADDR_W'(OFS_COUNT):   rd_data = count_q;
      ADDR_W'(OFS_CTRL):    rd_data = ctrl_word(ctrl_q);
      ADDR_W'(OFS_RAW):     rd_data = flags(1'b0, raw_q);
      ADDR_W'(OFS_MASKED):  rd_data = flags(1'b0, raw_q && ctrl_q.irq_en);
      ADDR_W'(OFS_TEST):    rd_data = test_word(test_q);
      ADDR_W'(OFS_CAUSE):   rd_data = flags(cause_rst_q, raw_q);
      ADDR_W'(OFS_KEYLOCK): rd_data = flags(1'b0, locked_q);
      default:              rd_data = '0;
    endcase
  end

endmodule

// File: rtl/wdog_lockable.sv
module wdog_lockable
  import wdog_lockable_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter logic [DATA_W-1:0] KEY = DATA_W'(UNLOCK_KEY)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              dbg_halt,
  output logic              irq,
  output logic              nmi,
  output logic              rst_req
);

  logic [DATA_W-1:0] reload_q, count_q;
  ctrl_t             ctrl_q;
  test_t             test_q;
  logic              locked_q, reload_wr, ack_wr;
  logic              raw_q, cause_rst_q, rst_req_q;
  logic              masked;

  wdog_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .KEY(KEY)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .reload_q(reload_q), .ctrl_q(ctrl_q), .test_q(test_q), .locked_q(locked_q),
    .reload_wr(reload_wr), .ack_wr(ack_wr)
  );

  wdog_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_n), .reload_wr(reload_wr), .reload_data(wr_data),
    .ack_wr(ack_wr), .reload_q(reload_q), .ctrl_q(ctrl_q), .test_q(test_q),
    .dbg_halt(dbg_halt), .count_q(count_q), .raw_q(raw_q),
    .cause_rst_q(cause_rst_q), .rst_req_q(rst_req_q)
  );

  wdog_rdmux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .rd_addr(rd_addr), .reload_q(reload_q), .count_q(count_q), .ctrl_q(ctrl_q),
    .test_q(test_q), .locked_q(locked_q), .raw_q(raw_q), .cause_rst_q(cause_rst_q),
    .rd_data(rd_data)
  );

  assign masked  = raw_q && ctrl_q.irq_en;
  assign irq     = masked && !ctrl_q.irq_kind;
  assign nmi     = masked && ctrl_q.irq_kind;
  assign rst_req = rst_req_q;

  assert_line_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq, nmi}));

  assert_line_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq || nmi) |-> (raw_q && ctrl_q.irq_en));

endmodule

// File: tb/wdog_lockable_test.sv
`timescale 1ns/100ps
module wdog_lockable_test;

  localparam int DW = 32;
  localparam int AW = 4;
  localparam logic [31:0] KEYV = 32'h1ACC_E551;

  localparam logic [3:0] A_RELOAD = 4'd0, A_COUNT = 4'd1, A_CTRL = 4'd2, A_ACK = 4'd3,
                         A_RAW = 4'd4, A_MASKED = 4'd5, A_TEST = 4'd6, A_CAUSE = 4'd7,
                         A_LOCK = 4'd8;

  localparam int K_RD = 0, K_IRQ = 1, K_NMI = 2, K_RST = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic dbg_halt = 1'b0;
  logic irq, nmi, rst_req;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  wdog_lockable #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .dbg_halt(dbg_halt),
    .irq(irq), .nmi(nmi), .rst_req(rst_req)
  );

  // monitor: compares queued expectations just after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        case (it.kind)
          K_IRQ:   act = {31'b0, irq};
          K_NMI:   act = {31'b0, nmi};
          K_RST:   act = {31'b0, rst_req};
          default: act = rd_data;
        endcase
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic push(input int k, input logic [31:0] e, input string t);
    item_t it;
    it.kind = k; it.exp = e; it.tag = t;
    sb.push_back(it);
  endtask

  task automatic chk_rd(input logic [3:0] a, input logic [31:0] e, input string t);
    rd_addr = a;
    push(K_RD, e, t);
    @(negedge clk);
  endtask

  task automatic chk_pin(input int k, input logic e, input string t);
    push(k, {31'b0, e}, t);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    dbg_halt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog req=all actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R1 reset state
    chk_pin(K_IRQ, 1'b0, "R1 irq");
    chk_pin(K_NMI, 1'b0, "R1 nmi");
    chk_pin(K_RST, 1'b0, "R1 rst_req");
    chk_rd(A_LOCK,   32'h0, "R1 lock");
    chk_rd(A_RELOAD, 32'hFFFF_FFFF, "R1 reload");
    chk_rd(A_COUNT,  32'hFFFF_FFFF, "R1 count");
    chk_rd(A_CTRL,   32'h0, "R1 ctrl");
    chk_rd(A_TEST,   32'h0, "R1 test");
    chk_rd(A_RAW,    32'h0, "R1 raw");
    chk_rd(A_CAUSE,  32'h0, "R1 cause");

    // R2 / R4 / R8 first timeout, no reset stage
    do_reset();
    wr(A_CTRL, 32'h1);
    wr(A_RELOAD, 32'd3);
    chk_rd(A_COUNT, 32'd3, "R2 count after load");
    chk_rd(A_COUNT, 32'd2, "R2 count -1");
    chk_rd(A_COUNT, 32'd1, "R2 count -2");
    chk_rd(A_COUNT, 32'd0, "R2 count -3");
    chk_pin(K_IRQ, 1'b1, "R8 irq on timeout");
    chk_pin(K_NMI, 1'b0, "R8 nmi low");
    chk_rd(A_RAW, 32'h1, "R4 raw after first zero");
    chk_rd(A_COUNT, 32'd2, "R4 reloaded count");
    chk_rd(A_MASKED, 32'h1, "R8 masked");
    chk_rd(A_RELOAD, 32'd3, "R2 reload readback");
    chk_pin(K_RST, 1'b0, "R5 no request without reset enable");
    chk_rd(A_CAUSE, 32'h1, "R6 cause mirrors raw");

    // R5 / R7 reset request
    do_reset();
    wr(A_CTRL, 32'h3);
    wr(A_RELOAD, 32'd3);
    chk_rd(A_COUNT, 32'd3, "R2 count j0");
    chk_rd(A_COUNT, 32'd2, "R2 count j1");
    chk_rd(A_COUNT, 32'd1, "R2 count j2");
    chk_rd(A_COUNT, 32'd0, "R2 count j3");
    chk_rd(A_RAW, 32'h1, "R4 raw j4");
    chk_rd(A_COUNT, 32'd2, "R4 count j5");
    chk_rd(A_COUNT, 32'd1, "R4 count j6");
    chk_pin(K_RST, 1'b0, "R5 request not yet");
    chk_rd(A_COUNT, 32'd0, "R4 count j7");
    chk_pin(K_RST, 1'b1, "R5 request on second zero");
    chk_rd(A_CAUSE, 32'h1, "R5 cause bit1 stays clear");
    wr(A_ACK, 32'hDEAD_BEEF);
    chk_pin(K_RST, 1'b1, "R5 request sticky after ack");
    chk_rd(A_RAW, 32'h0, "R7 ack clears raw");
    chk_rd(A_COUNT, 32'd2, "R7 ack reloads");

    // R6 test mode
    do_reset();
    wr(A_TEST, 32'h1);
    wr(A_CTRL, 32'h3);
    wr(A_RELOAD, 32'd3);
    chk_rd(A_COUNT, 32'd3, "R2 count t0");
    chk_rd(A_COUNT, 32'd2, "R2 count t1");
    chk_rd(A_COUNT, 32'd1, "R2 count t2");
    chk_rd(A_COUNT, 32'd0, "R2 count t3");
    chk_rd(A_RAW, 32'h1, "R4 raw t4");
    chk_rd(A_COUNT, 32'd2, "R4 count t5");
    chk_rd(A_COUNT, 32'd1, "R4 count t6");
    chk_rd(A_COUNT, 32'd0, "R4 count t7");
    chk_pin(K_RST, 1'b0, "R6 request suppressed");
    chk_pin(K_IRQ, 1'b1, "R6 interrupt raised");
    chk_rd(A_CAUSE, 32'h3, "R6 cause bits");
    wr(A_ACK, 32'h0);
    chk_rd(A_COUNT, 32'd3, "R7 count reloaded");
    chk_rd(A_CAUSE, 32'h0, "R7 cause cleared");

    // R3 / R8 / R9
    do_reset();
    wr(A_RELOAD, 32'h0);
    chk_rd(A_RAW, 32'h1, "R3 zero load raises raw");
    chk_pin(K_IRQ, 1'b0, "R8 irq masked off");
    chk_rd(A_MASKED, 32'h0, "R8 masked off");
    chk_rd(A_COUNT, 32'h0, "R3 count zero");
    wr(A_CTRL, 32'h5);
    chk_pin(K_NMI, 1'b1, "R8 nmi selected");
    chk_pin(K_IRQ, 1'b0, "R8 irq not selected");
    chk_rd(A_MASKED, 32'h1, "R8 masked on");
    wr(A_CTRL, 32'h0);
    chk_pin(K_IRQ, 1'b1, "R8 irq after type cleared");
    chk_rd(A_CTRL, 32'h1, "R9 enable sticky");

    // R10 stall
    do_reset();
    wr(A_TEST, 32'h100);
    wr(A_CTRL, 32'h1);
    wr(A_RELOAD, 32'd10);
    dbg_halt = 1'b1;
    chk_rd(A_COUNT, 32'd10, "R10 halted s0");
    chk_rd(A_COUNT, 32'd10, "R10 halted s1");
    dbg_halt = 1'b0;
    chk_rd(A_COUNT, 32'd10, "R10 halted s2");
    chk_rd(A_COUNT, 32'd9, "R10 resumed");
    wr(A_TEST, 32'h0);
    dbg_halt = 1'b1;
    wr(A_RELOAD, 32'd10);
    chk_rd(A_COUNT, 32'd10, "R10 no stall u0");
    chk_rd(A_COUNT, 32'd9, "R10 halt ignored");
    dbg_halt = 1'b0;

    // R11 lock
    do_reset();
    wr(A_RELOAD, 32'h0);
    wr(A_LOCK, 32'h1234_5678);
    chk_rd(A_LOCK, 32'h1, "R11 locked");
    wr(A_RELOAD, 32'd5);
    chk_rd(A_RELOAD, 32'h0, "R11 reload blocked");
    wr(A_CTRL, 32'h1);
    chk_rd(A_CTRL, 32'h0, "R11 ctrl blocked");
    wr(A_ACK, 32'h0);
    chk_rd(A_RAW, 32'h1, "R11 ack blocked");
    wr(A_TEST, 32'h101);
    chk_rd(A_TEST, 32'h1, "R11 test bit0 writable");
    wr(A_LOCK, KEYV);
    chk_rd(A_LOCK, 32'h0, "R11 unlocked");
    wr(A_RELOAD, 32'd5);
    chk_rd(A_RELOAD, 32'd5, "R11 reload after unlock");
    wr(A_LOCK, KEYV ^ 32'h1);
    chk_rd(A_LOCK, 32'h1, "R11 relocked");

    // R12 unmapped and read-only
    do_reset();
    wr(4'd12, 32'hFFFF_FFFF);
    wr(4'd9, 32'd5);
    wr(A_COUNT, 32'h0);
    wr(A_RAW, 32'h1);
    chk_rd(4'd12, 32'h0, "R12 read 12");
    chk_rd(4'd9, 32'h0, "R12 read 9");
    chk_rd(4'd15, 32'h0, "R12 read 15");
    chk_rd(A_ACK, 32'h0, "R12 read ack offset");
    chk_rd(A_RELOAD, 32'hFFFF_FFFF, "R12 reload untouched");
    chk_rd(A_CTRL, 32'h0, "R12 ctrl untouched");
    chk_rd(A_TEST, 32'h0, "R12 test untouched");
    chk_rd(A_COUNT, 32'hFFFF_FFFF, "R12 count untouched");
    chk_rd(A_RAW, 32'h0, "R12 raw untouched");
    chk_rd(A_LOCK, 32'h0, "R12 lock untouched");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule